// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block turns the core clock into the timing strobes that an SPI shifter uses to place its serial clock edges. An 8-bit prescale field selects the division ratio. A build-time parameter chooses how that field is read. The compact encoding gives even ratios from 4 to 30. The wide encoding multiplies a 4-bit mantissa by a power of two, giving ratios up to 1920.

While a word is in flight (`run_i` high), the block emits a one-cycle strobe at the end of each half period of the serial clock. A second output marks which of those strobes closes the high half. The active ratio is also presented as a binary number. The ratio is taken from the field only while the shifter is idle, so a word is always clocked at one rate. Working out a field value from a target frequency is left to software.

Top module: `spi_sck_prescaler`

## Requirements
- R1: Wide encoding (EXT_MODE=1): mantissa = field[3:0], exponent = {field[7], field[6], field[4]} with field[7] as MSB; divisor = mantissa × 2^exponent; field[5] has no effect.
- R2: Wide encoding: any field whose product is below 2 (mantissa 0, or mantissa 1 with exponent 0) yields divisor 2.
- R3: Compact encoding (EXT_MODE=0): with v = field[4:0] and v ≥ 0x12, divisor = 2 × (v − 0x10), which spans 4 to 30; field[7:5] has no effect.
- R4: Compact encoding: v below 0x12 yields divisor 4.
- R5: While `run_i` is low, `divisor_o` shows the decoded divisor of the field sampled at the previous clock edge.
- R6: A change of the field while `run_i` is high changes neither `divisor_o` nor the strobe timing until `run_i` has been low for one edge.
- R7: Counting run cycles n from 0, starting with the first cycle in which `run_i` is high, `sck_tick_o` is high exactly when (n+1) mod d equals floor(d/2) or 0. `tick_high_end_o` is high exactly in the first case. The high half therefore lasts floor(d/2) cycles and the low half lasts ceil(d/2) cycles.
- R8: `sck_tick_o` and `tick_high_end_o` are low whenever `run_i` is low, and each new run restarts the count at n = 0.
- R9: After reset, `divisor_o` holds the smallest legal divisor of the selected encoding (2 wide, 4 compact).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | High while the shifter moves a word |
| presc_field_i | input | 8 | Prescale field from the configuration register |
| sck_tick_o | output | 1 | One-cycle strobe at the end of each serial clock half period |
| tick_high_end_o | output | 1 | Marks the strobe that ends the high half |
| divisor_o | output | 11 | Divisor in effect, in core clock cycles |

## Verification
The bench aims at the clamp points: a wide mantissa of 0 or 1 at exponent 0, and compact values just below and at 0x12. A decoder that missed the clamp would report divisor 0 or 1, or a wrong compact ratio, and would give the counter a zero-length half. Odd wide divisors such as 3, 5 and 15 exercise the floor/ceil split. A design that swapped the halves, or rounded both the same way, would misplace the high-end marker or slip the period by one cycle. Field changes made in the middle of a run, and the top exponent bit sitting above unused bit 5, catch a design that retimes a word mid-flight or shifts the split exponent bits into the wrong place.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;
  localparam int FIELD_W  = 8;
  localparam int MANT_W   = 4;
  localparam int EXP_W    = 3;
  localparam int DIV_W    = MANT_W + (1 << EXP_W) - 1;
  localparam int EXT_MIN  = 2;
  localparam int CMP_MIN  = 4;
  localparam int EXT_MAX  = ((1 << MANT_W) - 1) << ((1 << EXP_W) - 1);
  localparam int CMP_MAX  = 30;

  // wide form: mantissa in the low nibble, exponent split around bit 5
  function automatic logic [DIV_W-1:0] wide_divisor(input logic [FIELD_W-1:0] f);
    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  expo;
    logic [DIV_W-1:0]  d;
    mant = f[3:0];
    expo = {f[7:6], f[4]};
    d = DIV_W'(mant) << expo;
    if (d < DIV_W'(EXT_MIN)) d = DIV_W'(EXT_MIN);
    return d;
  endfunction

  // compact form: 0x10 + d/2 in five bits
  function automatic logic [DIV_W-1:0] compact_divisor(input logic [FIELD_W-1:0] f);
    logic [4:0] v;
    v = f[4:0];
    if (v < 5'h12) return DIV_W'(CMP_MIN);
    return DIV_W'({v[3:0], 1'b0});
  endfunction
endpackage

// File: rtl/presc_decode.sv
module presc_decode
  import spi_presc_pkg::*;
#(
  parameter bit EXT_MODE = 1'b1
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [DIV_W-1:0]   div_o
);
  generate
    if (EXT_MODE) begin : g_wide
      always_comb div_o = wide_divisor(field_i);
    end else begin : g_compact
      always_comb div_o = compact_divisor(field_i);
    end
  endgenerate
endmodule

// File: rtl/presc_div_hold.sv
module presc_div_hold
  import spi_presc_pkg::*;
#(
  parameter int RESET_DIV = EXT_MIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_in,
  output logic [DIV_W-1:0] div_o
);
  logic load_en;
  assign load_en = !run_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_o <= DIV_W'(RESET_DIV);
    else if (load_en) div_o <= div_in;
  end

  AST_DIV_FROZEN_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_i) |-> $stable(div_o)); // R6
  AST_DIV_FOLLOWS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (div_o == $past(div_in))); // R5
endmodule

// File: rtl/presc_phase_gen.sv
module presc_phase_gen
  import spi_presc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             high_end_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             low_half_q;
  logic [DIV_W-1:0] half_len;
  logic             half_done;

  // high half gets floor(d/2), low half gets the remainder
  always_comb begin
    half_len  = low_half_q ? (div_i - (div_i >> 1)) : (div_i >> 1);
    half_done = run_i && (cnt_q == half_len - DIV_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      low_half_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q      <= '0;
      low_half_q <= 1'b0;
    end else if (half_done) begin
      cnt_q      <= '0;
      low_half_q <= !low_half_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign tick_o     = half_done;
  assign high_end_o = half_done && !low_half_q;

  AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !tick_o && !high_end_o); // R8
  AST_CNT_IN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < half_len)); // R7
  AST_HALVES_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && high_end_o) |=> !high_end_o); // R7
  AST_RUN_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> (cnt_q == '0) && !low_half_q); // R8
endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
  import spi_presc_pkg::*;
#(
  parameter bit EXT_MODE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic [FIELD_W-1:0] presc_field_i,
  output logic               sck_tick_o,
  output logic               tick_high_end_o,
  output logic [DIV_W-1:0]   divisor_o
);
  localparam int MIN_DIV = EXT_MODE ? EXT_MIN : CMP_MIN;
  localparam int MAX_DIV = EXT_MODE ? EXT_MAX : CMP_MAX;

  logic [DIV_W-1:0] decoded_div;
  logic [DIV_W-1:0] active_div;

  presc_decode #(.EXT_MODE(EXT_MODE)) u_decode (
    .field_i (presc_field_i),
    .div_o   (decoded_div)
  );

  presc_div_hold #(.RESET_DIV(MIN_DIV)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_i),
    .div_in (decoded_div),
    .div_o  (active_div)
  );

  presc_phase_gen u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .div_i      (active_div),
    .tick_o     (sck_tick_o),
    .high_end_o (tick_high_end_o)
  );

  assign divisor_o = active_div;

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor_o >= DIV_W'(MIN_DIV)) && (divisor_o <= DIV_W'(MAX_DIV))); // R2

  generate
    if (!EXT_MODE) begin : g_even_chk
      AST_COMPACT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        divisor_o[0] == 1'b0); // R3
    end
  endgenerate
endmodule

// File: tb/tb_spi_sck_prescaler.sv
module tb_spi_sck_prescaler;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [7:0]  f_ext = 8'h00;
  logic [7:0]  f_cmp = 8'h00;
  logic        tick_e, hend_e, tick_c, hend_c;
  logic [10:0] div_e, div_c;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sck_prescaler #(.EXT_MODE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .presc_field_i(f_ext),
    .sck_tick_o(tick_e), .tick_high_end_o(hend_e), .divisor_o(div_e));

  spi_sck_prescaler #(.EXT_MODE(1'b0)) dut_cmp (
    .clk(clk), .rst_n(rst_n), .run_i(run), .presc_field_i(f_cmp),
    .sck_tick_o(tick_c), .tick_high_end_o(hend_c), .divisor_o(div_c));

  function automatic int exp_wide(input logic [7:0] f);
    int m, e, d;
    m = int'(f & 8'h0F);
    e = int'(f >> 6) * 2 + int'(f[4]);
    d = m * (1 << e);
    return (d < 2) ? 2 : d;
  endfunction

  function automatic int exp_compact(input logic [7:0] f);
    int v;
    v = int'(f & 8'h1F);
    return (v < 18) ? 4 : (v - 16) * 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one word: program fields while idle, run ncyc cycles, optionally poke the fields mid-run
  task automatic do_word(input logic [7:0] fe, input logic [7:0] fc, input int ncyc, input bit poke);
    int de, dc, he, hc;
    @(negedge clk);
    f_ext = fe; f_cmp = fc; run = 1'b0;
    @(negedge clk); @(negedge clk);
    de = exp_wide(fe); dc = exp_compact(fc);
    he = de / 2; hc = dc / 2;
    chk("R1/R2/R5 wide divisor", int'(div_e), de);
    chk("R3/R4/R5 compact divisor", int'(div_c), dc);
    run = 1'b1;
    for (int n = 0; n < ncyc; n++) begin
      if (n > 0) @(negedge clk);
      #1;
      chk("R7 wide tick", int'(tick_e), int'(((n+1) % de == he) || ((n+1) % de == 0)));
      chk("R7 wide high end", int'(hend_e), int'((n+1) % de == he));
      chk("R7 compact tick", int'(tick_c), int'(((n+1) % dc == hc) || ((n+1) % dc == 0)));
      chk("R7 compact high end", int'(hend_c), int'((n+1) % dc == hc));
      if (poke && n == ncyc / 2) begin
        f_ext = ~fe; f_cmp = ~fc;
      end
      if (poke && n > ncyc / 2) begin
        chk("R6 wide divisor held", int'(div_e), de);
        chk("R6 compact divisor held", int'(div_c), dc);
      end
    end
    @(negedge clk);
    run = 1'b0;
    #1;
    chk("R8 wide no tick idle", int'(tick_e | hend_e), 0);
    chk("R8 compact no tick idle", int'(tick_c | hend_c), 0);
    @(negedge clk);
    chk("R5 wide reload after run", int'(div_e), exp_wide(f_ext));
    chk("R5 compact reload after run", int'(div_c), exp_compact(f_cmp));
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    #(CLK_PERIOD * 2);
    @(negedge clk);
    chk("R9 wide reset divisor", int'(div_e), 2);
    chk("R9 compact reset divisor", int'(div_c), 4);
    chk("R9 no tick in reset", int'(tick_e | tick_c), 0);
    rst_n = 1'b1;
    // directed corners
    do_word(8'h00, 8'h00, 8, 1'b0);   // R2 mantissa 0, R4 low clamp
    do_word(8'h01, 8'h11, 8, 1'b0);   // R2 mantissa 1 exp 0, R4 just below 0x12
    do_word(8'h03, 8'h12, 12, 1'b0);  // odd 3, R3 first legal value 4
    do_word(8'h05, 8'h1F, 40, 1'b1);  // odd 5, R3 top value 30, R6 poke
    do_word(8'h2F, 8'hF3, 40, 1'b0);  // R1 bit5 ignored -> 15, R3 upper bits ignored
    do_word(8'h81, 8'hE5, 12, 1'b0);  // R1 exponent MSB -> 1<<4 = 16
    do_word(8'h12, 8'h14, 20, 1'b1);  // R1 exponent bit 4 -> 4
    do_word(8'hDF, 8'h1A, 40, 1'b1);  // R1 maximum 1920, short run
    // random words
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a, b;
      int len;
      a = 8'($urandom);
      b = 8'($urandom);
      len = 2 * exp_wide(a) + 3;
      if (len > 600) len = 600;
      do_word(a, b, len, i[0]);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule